// File: doc/BRIEF.md
# Segment Base Register File With Kernel Swap

This block keeps three 64-bit base pointers: the thread base, the general base and a shadow copy of the general base that the kernel keeps for itself. The address unit reads the live thread and general bases from two dedicated outputs every cycle. Software reaches the pointers in three ways:

- A privileged model-specific-register port that selects one of the three pointers by a 32-bit address.
- Four fast instructions that read or write the thread base or the general base directly.
- A swap operation that exchanges the general base with its kernel shadow in a single step.

Each request is a 3-bit operation code presented for one cycle. The block returns its result on registered outputs in the following cycle. Those outputs are the read data with a valid flag and two fault flags. One flag reports a general-protection fault and the other an invalid-opcode fault. A faulting request changes no register. The fast instructions are allowed only while a feature-enable input is high. The privileged port and the swap ignore that input and depend on the privilege level instead.

Top module: `segbase_regfile`

## Requirements
- R1: On synchronous reset, all three pointers become zero. Read data, the read-valid flag and both fault flags are also zero.
- R2: At privilege 0, an MSR write or read reaches a pointer selected by address. Address 0xC0000100 selects the thread base, 0xC0000101 the general base and 0xC0000102 the kernel shadow. A read returns the value with rd_valid_o high in the cycle after the request. Operation codes: 0 idle, 1 MSR read, 2 MSR write, 3 read thread base, 4 read general base, 5 write thread base, 6 write general base, 7 swap.
- R3: An MSR read or write to any other address raises fault_gp_o and changes no pointer.
- R4: An MSR access or a swap at any privilege other than 0 raises fault_gp_o and changes no pointer.
- R5: A swap at privilege 0 exchanges the general base and the kernel shadow in one cycle. gs_base_o shows the former shadow value in the next cycle.
- R6: With the feature enable high, the four fast operations read or write their pointer at any privilege level.
- R7: With the feature enable low, a fast operation raises fault_ud_o only. fault_gp_o stays low and no pointer changes.
- R8: A write of a non-canonical value on any path raises fault_gp_o, and the value is discarded. A value is canonical when bits 63 down to VA_BITS-1 are all equal (bits 63..47 with VA_BITS=48).
- R9: The MSR path works whether the feature enable is high or low.
- R10: An idle cycle gives rd_valid_o, fault_gp_o and fault_ud_o all low in the next cycle. At most one fault flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (see R2) |
| msr_addr_i | input | 32 | MSR address for operations 1 and 2 |
| wdata_i | input | DATA_W | Write data |
| cpl_i | input | 2 | Current privilege level |
| fast_en_i | input | 1 | Feature enable for the fast operations |
| rd_data_o | output | DATA_W | Read result, zero unless valid |
| rd_valid_o | output | 1 | Read result valid |
| fault_gp_o | output | 1 | General-protection fault |
| fault_ud_o | output | 1 | Invalid-opcode fault |
| fs_base_o | output | DATA_W | Live thread base |
| gs_base_o | output | DATA_W | Live general base |

## Verification
The bench builds the block with DATA_W=64 and VA_BITS=48. This exposes the canonical boundary at bit 47. At that boundary, the values 0x00007FFF_FFFFFFFF and 0xFFFF8000_00000000 must be accepted, and 0x00008000_00000000 must be refused. A behavioural model in the bench runs alongside the block and is compared on every cycle. The stimulus covers privilege 3 against the MSR port and the swap, and the feature enable toggled against both paths. It also includes back-to-back swaps and reads of the kernel shadow that is otherwise hidden.

// File: rtl/segbase_pkg.sv
package segbase_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_MSR_RD = 3'd1,
    OP_MSR_WR = 3'd2,
    OP_RD_FS  = 3'd3,
    OP_RD_GS  = 3'd4,
    OP_WR_FS  = 3'd5,
    OP_WR_GS  = 3'd6,
    OP_SWAP   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FS   = 2'd1,
    SEL_GS   = 2'd2,
    SEL_KGS  = 2'd3
  } sel_e;

endpackage

// File: rtl/segbase_canon.sv
module segbase_canon #(
  parameter int DATA_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic [DATA_W-1:0] value_i,
  output logic              ok_o
);
  localparam int TOP_W = DATA_W - VA_BITS + 1;

  logic [TOP_W-1:0] upper;
  assign upper = value_i[DATA_W-1:VA_BITS-1];
  assign ok_o  = (upper == '0) || (upper == '1);
endmodule

// File: rtl/segbase_ctrl.sv
module segbase_ctrl #(
  parameter logic [31:0] ADDR_FS  = 32'hC000_0100,
  parameter logic [31:0] ADDR_GS  = 32'hC000_0101,
  parameter logic [31:0] ADDR_KGS = 32'hC000_0102
) (
  input  segbase_pkg::op_e  op_i,
  input  logic [31:0]       msr_addr_i,
  input  logic [1:0]        cpl_i,
  input  logic              fast_en_i,
  input  logic              wdata_ok_i,
  output segbase_pkg::sel_e sel_o,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic              swap_en_o,
  output logic              gp_o,
  output logic              ud_o
);
  import segbase_pkg::*;

  logic   is_msr, is_fast, is_wr, is_rd, privileged;
  sel_e   msr_sel;

  always_comb begin
    unique case (msr_addr_i)
      ADDR_FS:  msr_sel = SEL_FS;
      ADDR_GS:  msr_sel = SEL_GS;
      ADDR_KGS: msr_sel = SEL_KGS;
      default:  msr_sel = SEL_NONE;
    endcase
  end

  always_comb begin
    is_msr  = (op_i == OP_MSR_RD) || (op_i == OP_MSR_WR);
    is_fast = (op_i == OP_RD_FS) || (op_i == OP_RD_GS) ||
              (op_i == OP_WR_FS) || (op_i == OP_WR_GS);
    is_wr   = (op_i == OP_MSR_WR) || (op_i == OP_WR_FS) || (op_i == OP_WR_GS);
    is_rd   = (op_i == OP_MSR_RD) || (op_i == OP_RD_FS) || (op_i == OP_RD_GS);
    privileged = is_msr || (op_i == OP_SWAP);

    unique case (op_i)
      OP_MSR_RD, OP_MSR_WR: sel_o = msr_sel;
      OP_RD_FS, OP_WR_FS:   sel_o = SEL_FS;
      OP_RD_GS, OP_WR_GS:   sel_o = SEL_GS;
      default:              sel_o = SEL_NONE;
    endcase

    ud_o = is_fast && !fast_en_i;
    gp_o = !ud_o && ((privileged && (cpl_i != 2'd0)) ||
                     (is_msr && (msr_sel == SEL_NONE)) ||
                     (is_wr && !wdata_ok_i));

    wr_en_o   = is_wr && !ud_o && !gp_o;
    rd_en_o   = is_rd && !ud_o && !gp_o;
    swap_en_o = (op_i == OP_SWAP) && !gp_o;
  end
endmodule

// File: rtl/segbase_store.sv
module segbase_store #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  segbase_pkg::sel_e sel_i,
  input  logic              wr_en_i,
  input  logic              swap_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] fs_q,
  output logic [DATA_W-1:0] gs_q,
  output logic [DATA_W-1:0] kgs_q
);
  import segbase_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= '0;
      gs_q  <= '0;
      kgs_q <= '0;
    end else if (swap_en_i) begin
      gs_q  <= kgs_q;
      kgs_q <= gs_q;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_FS:  fs_q  <= wdata_i;
        SEL_GS:  gs_q  <= wdata_i;
        SEL_KGS: kgs_q <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/segbase_regfile.sv
module segbase_regfile #(
  parameter int          DATA_W   = 64,
  parameter int          VA_BITS  = 48,
  parameter logic [31:0] ADDR_FS  = 32'hC000_0100,
  parameter logic [31:0] ADDR_GS  = 32'hC000_0101,
  parameter logic [31:0] ADDR_KGS = 32'hC000_0102
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [31:0]       msr_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        cpl_i,
  input  logic              fast_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              fault_gp_o,
  output logic              fault_ud_o,
  output logic [DATA_W-1:0] fs_base_o,
  output logic [DATA_W-1:0] gs_base_o
);
  import segbase_pkg::*;

  op_e               op;
  sel_e              sel;
  logic              wdata_ok, wr_en, rd_en, swap_en, gp, ud;
  logic [DATA_W-1:0] fs_q, gs_q, kgs_q, rd_mux;

  assign op = op_e'(op_i);

  segbase_canon #(.DATA_W(DATA_W), .VA_BITS(VA_BITS)) u_canon (
    .value_i (wdata_i),
    .ok_o    (wdata_ok)
  );

  segbase_ctrl #(.ADDR_FS(ADDR_FS), .ADDR_GS(ADDR_GS), .ADDR_KGS(ADDR_KGS)) u_ctrl (
    .op_i       (op),
    .msr_addr_i (msr_addr_i),
    .cpl_i      (cpl_i),
    .fast_en_i  (fast_en_i),
    .wdata_ok_i (wdata_ok),
    .sel_o      (sel),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .swap_en_o  (swap_en),
    .gp_o       (gp),
    .ud_o       (ud)
  );

  segbase_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (sel),
    .wr_en_i   (wr_en),
    .swap_en_i (swap_en),
    .wdata_i   (wdata_i),
    .fs_q      (fs_q),
    .gs_q      (gs_q),
    .kgs_q     (kgs_q)
  );

  always_comb begin
    unique case (sel)
      SEL_FS:  rd_mux = fs_q;
      SEL_GS:  rd_mux = gs_q;
      SEL_KGS: rd_mux = kgs_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      fault_gp_o <= 1'b0;
      fault_ud_o <= 1'b0;
    end else begin
      rd_data_o  <= rd_en ? rd_mux : '0;
      rd_valid_o <= rd_en;
      fault_gp_o <= gp;
      fault_ud_o <= ud;
    end
  end

  assign fs_base_o = fs_q;
  assign gs_base_o = gs_q;
endmodule

// File: rtl/segbase_checker.sv
module segbase_checker #(
  parameter int DATA_W  = 64,
  parameter int VA_BITS = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [1:0]        cpl_i,
  input logic              fast_en_i,
  input logic              rd_valid_o,
  input logic              fault_gp_o,
  input logic              fault_ud_o,
  input logic [DATA_W-1:0] fs_base_o,
  input logic [DATA_W-1:0] gs_base_o,
  input logic [DATA_W-1:0] kgs
);
  logic is_fast, noncanon;
  assign is_fast  = (op_i >= 3'd3) && (op_i <= 3'd6);
  assign noncanon = !((wdata_i >> (VA_BITS - 1)) == '0 ||
                      (wdata_i >> (VA_BITS - 1)) == ({DATA_W{1'b1}} >> (VA_BITS - 1)));

  assert_fault_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_gp_o, fault_ud_o}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0) |=> (!rd_valid_o && !fault_gp_o && !fault_ud_o));

  assert_unpriv_gp_R4: assert property (@(posedge clk) disable iff (rst)
    (((op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd7)) && (cpl_i != 2'd0))
      |=> (fault_gp_o && gs_base_o == $past(gs_base_o) && kgs == $past(kgs)));

  assert_swap_exchange_R5: assert property (@(posedge clk) disable iff (rst)
    ((op_i == 3'd7) && (cpl_i == 2'd0))
      |=> (gs_base_o == $past(kgs) && kgs == $past(gs_base_o)));

  assert_fast_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (is_fast && !fast_en_i)
      |=> (fault_ud_o && !fault_gp_o && fs_base_o == $past(fs_base_o) &&
           gs_base_o == $past(gs_base_o)));

  assert_noncanon_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (((op_i == 3'd5) || (op_i == 3'd6)) && fast_en_i && noncanon)
      |=> (fault_gp_o && fs_base_o == $past(fs_base_o) && gs_base_o == $past(gs_base_o)));
endmodule

bind segbase_regfile segbase_checker #(.DATA_W(DATA_W), .VA_BITS(VA_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .wdata_i    (wdata_i),
  .cpl_i      (cpl_i),
  .fast_en_i  (fast_en_i),
  .rd_valid_o (rd_valid_o),
  .fault_gp_o (fault_gp_o),
  .fault_ud_o (fault_ud_o),
  .fs_base_o  (fs_base_o),
  .gs_base_o  (gs_base_o),
  .kgs        (kgs_q)
);

// File: tb/tb_segbase_regfile.sv
module tb_segbase_regfile;
  localparam int DW = 64;
  localparam int VA = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op;
  logic [31:0]   addr;
  logic [DW-1:0] wdata;
  logic [1:0]    cpl;
  logic          en;
  logic [DW-1:0] rd_data, fs_base, gs_base;
  logic          rd_valid, gp, ud;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] m_fs, m_gs, m_kgs;

  always #10 clk = ~clk;

  segbase_regfile #(.DATA_W(DW), .VA_BITS(VA)) dut (
    .clk(clk), .rst(rst), .op_i(op), .msr_addr_i(addr), .wdata_i(wdata),
    .cpl_i(cpl), .fast_en_i(en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .fault_gp_o(gp), .fault_ud_o(ud), .fs_base_o(fs_base), .gs_base_o(gs_base)
  );

  task automatic chk(input string req, input string what, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic canon(input logic [DW-1:0] v);
    logic [DW-1:0] up;
    up = v >> (VA - 1);
    return (up == 0) || (up == ({DW{1'b1}} >> (VA - 1)));
  endfunction

  task automatic step(input string req, input logic [2:0] o, input logic [31:0] a,
                      input logic [DW-1:0] d, input logic [1:0] c, input logic e);
    logic          x_gp, x_ud, x_rv, wr, rd, msr;
    logic [1:0]    tgt;
    logic [DW-1:0] x_rd;
    op = o; addr = a; wdata = d; cpl = c; en = e;
    msr = (o == 3'd1) || (o == 3'd2);
    wr  = (o == 3'd2) || (o == 3'd5) || (o == 3'd6);
    rd  = (o == 3'd1) || (o == 3'd3) || (o == 3'd4);
    tgt = 2'd0;
    if (msr) begin
      if (a == 32'hC000_0100) tgt = 2'd1;
      else if (a == 32'hC000_0101) tgt = 2'd2;
      else if (a == 32'hC000_0102) tgt = 2'd3;
    end else if (o == 3'd3 || o == 3'd5) tgt = 2'd1;
    else if (o == 3'd4 || o == 3'd6) tgt = 2'd2;
    x_ud = (o >= 3'd3) && (o <= 3'd6) && !e;
    x_gp = 1'b0;
    if (!x_ud) begin
      if ((msr || o == 3'd7) && c != 2'd0) x_gp = 1'b1;
      if (msr && tgt == 2'd0) x_gp = 1'b1;
      if (wr && !canon(d)) x_gp = 1'b1;
    end
    x_rv = rd && !x_gp && !x_ud;
    x_rd = '0;
    if (x_rv) x_rd = (tgt == 2'd1) ? m_fs : (tgt == 2'd2) ? m_gs : m_kgs;
    @(posedge clk);
    if (!x_gp && !x_ud) begin
      if (o == 3'd7) begin
        logic [DW-1:0] t;
        t = m_gs; m_gs = m_kgs; m_kgs = t;
      end else if (wr) begin
        if (tgt == 2'd1) m_fs = d;
        else if (tgt == 2'd2) m_gs = d;
        else if (tgt == 2'd3) m_kgs = d;
      end
    end
    @(negedge clk);
    chk(req, "rd_data", rd_data, x_rd);
    chk(req, "rd_valid", {63'd0, rd_valid}, {63'd0, x_rv});
    chk(req, "fault_gp", {63'd0, gp}, {63'd0, x_gp});
    chk(req, "fault_ud", {63'd0, ud}, {63'd0, x_ud});
    chk(req, "fs_base", fs_base, m_fs);
    chk(req, "gs_base", gs_base, m_gs);
  endtask

  localparam logic [31:0] AFS = 32'hC000_0100;
  localparam logic [31:0] AGS = 32'hC000_0101;
  localparam logic [31:0] AKG = 32'hC000_0102;

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_fs = '0; m_gs = '0; m_kgs = '0;
    rst = 1'b1; op = 3'd0; addr = '0; wdata = '0; cpl = '0; en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rd_data", rd_data, '0);
    chk("R1", "flags", {61'd0, rd_valid, gp, ud}, '0);
    chk("R1", "fs_base", fs_base, '0);
    chk("R1", "gs_base", gs_base, '0);
    rst = 1'b0;
    step("R1", 3'd1, AKG, '0, 2'd0, 1'b0);
    step("R10", 3'd0, '0, '0, 2'd0, 1'b1);
    // R2 / R9 : MSR path with enable low
    step("R9", 3'd2, AFS, 64'h0000_1234_5678_9ABC, 2'd0, 1'b0);
    step("R2", 3'd2, AGS, 64'hFFFF_8000_0000_0010, 2'd0, 1'b0);
    step("R2", 3'd2, AKG, 64'h0000_7FFF_FFFF_FFFF, 2'd0, 1'b1);
    step("R2", 3'd1, AFS, '0, 2'd0, 1'b0);
    step("R2", 3'd1, AKG, '0, 2'd0, 1'b1);
    // R3: unknown address
    step("R3", 3'd2, 32'hC000_0103, 64'h55, 2'd0, 1'b1);
    step("R3", 3'd1, 32'hC000_00FF, '0, 2'd0, 1'b1);
    // R4: unprivileged MSR and swap
    step("R4", 3'd2, AGS, 64'h77, 2'd3, 1'b1);
    step("R4", 3'd1, AFS, '0, 2'd1, 1'b1);
    step("R4", 3'd7, '0, '0, 2'd3, 1'b1);
    // R5: swap twice
    step("R5", 3'd7, '0, '0, 2'd0, 1'b0);
    step("R5", 3'd1, AKG, '0, 2'd0, 1'b0);
    step("R5", 3'd7, '0, '0, 2'd0, 1'b1);
    // R6: fast paths at privilege 3
    step("R6", 3'd5, '0, 64'h0000_0000_DEAD_BEEF, 2'd3, 1'b1);
    step("R6", 3'd6, '0, 64'hFFFF_FFFF_FFFF_F000, 2'd3, 1'b1);
    step("R6", 3'd3, '0, '0, 2'd3, 1'b1);
    step("R6", 3'd4, '0, '0, 2'd0, 1'b1);
    // R7: fast paths gated
    step("R7", 3'd5, '0, 64'h1, 2'd0, 1'b0);
    step("R7", 3'd6, '0, 64'h2, 2'd3, 1'b0);
    step("R7", 3'd3, '0, '0, 2'd0, 1'b0);
    step("R7", 3'd6, '0, 64'h8000_0000_0000_0000, 2'd3, 1'b0);
    // R8: non-canonical writes on every path
    step("R8", 3'd5, '0, 64'h0000_8000_0000_0000, 2'd0, 1'b1);
    step("R8", 3'd6, '0, 64'hFFFF_7FFF_FFFF_FFFF, 2'd0, 1'b1);
    step("R8", 3'd2, AKG, 64'h0001_0000_0000_0000, 2'd0, 1'b0);
    step("R8", 3'd1, AKG, '0, 2'd0, 1'b0);
    step("R8", 3'd5, '0, 64'hFFFF_8000_0000_0000, 2'd0, 1'b1);
    step("R10", 3'd0, AFS, 64'h99, 2'd0, 1'b1);
    step("R10", 3'd7, '0, '0, 2'd0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule